// File: doc/BRIEF.md
# Stereo Volume and Cross-Mix Butterfly

This block scales and mixes one stereo PCM stream, one sample pair at a time. It holds four attenuation settings: one for each channel onto itself and one for each channel onto the opposite output. Each output is the sum of two scaled inputs, so the same structure can set volume, mix both channels into both outputs, or swap the channels entirely.

Every attenuation setting counts in steps of one decibel. Settings arrive through a write port of one byte and are sampled with each accepted input pair. A new setting is therefore applied whole to the next pair, never to half a pair. Sums that go beyond the output range clip to the range limits.

Top module: `stereo_xmix`

## Requirements
- R1: After reset both direct settings are 0 (full level) and both cross settings are 255 (muted), so each input channel reaches its own output unchanged and nothing crosses over.
- R2: A write with `cfg_we` high stores `cfg_data` into the setting chosen by `cfg_sel`: 0 selects left-onto-left, 1 selects right-onto-right, 2 selects left-onto-right, 3 selects right-onto-left.
- R3: A setting n below 96 gives the coefficient g = B[n mod 6] >> floor(n/6), with B = {32768, 29205, 26029, 23198, 20675, 18427}. Unity is 32768, so n = 0 passes a sample exactly and n = 90 gives g = 1.
- R4: A setting of 96 or more, 255 included, gives a coefficient of zero. A pair whose two contributions to one output are both zeroed produces 0 on that output.
- R5: Each scaled term is floor(x * g / 32768). The left output is left times g(left-onto-left) plus right times g(right-onto-left). The right output is right times g(right-onto-right) plus left times g(left-onto-right).
- R6: A sum above 8388607 gives 8388607, and a sum below -8388608 gives -8388608. Sums inside that range pass without change.
- R7: A write in the same cycle as an accepted input pair does not change that pair. It applies to the next pair, and both outputs of a pair always use the same set of settings.
- R8: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, once for each pair, and is low at all other times. After reset `out_valid` is low and both outputs are 0.
- R9: With both direct settings at 255 and both cross settings at 0, the outputs carry the inputs swapped: the left output is the right input and the right output is the left input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pair strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| cfg_we | input | 1 | Setting write enable |
| cfg_sel | input | 2 | Setting select (R2 encoding) |
| cfg_data | input | 8 | Attenuation in dB steps |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
The input pairs are chosen so that each kind of fault shows up. Pairs with unequal, opposite-signed channels through reset settings show whether a path is swapped or leaks across. Single non-zero settings at 1, 6, 13 and 90 dB, applied to positive and negative full-scale values, show whether the coefficient law holds and whether truncation floors. Equal full-scale pairs with every setting at unity drive both saturation limits, and a full-scale pair of opposite signs shows that no clipping happens while the sum stays in range. Back-to-back pairs with a write landing on the first of them separate the coefficient snapshot from the settings, and also test the two-cycle timing of the strobe.

// File: rtl/xmix_pkg.sv
// Shared constants and types for the stereo cross-mix block.
// Assumes four mixing paths indexed as listed below; the index order
// matches the write-select encoding seen at the block's port.
package xmix_pkg;
    localparam int ATT_W   = 8;    // attenuation setting width
    localparam int FRAC_W  = 15;   // fractional bits of a coefficient
    localparam int COEF_W  = FRAC_W + 1; // unsigned coefficient, unity = 2**FRAC_W
    localparam int N_PATH  = 4;
    localparam int SEL_W   = $clog2(N_PATH);
    localparam int MUTE_AT = 96;   // first setting that gives zero gain
    localparam int STEPS   = 6;    // dB steps per halving of the gain

    // Path indices (also the write-select codes)
    localparam int P_LL = 0;   // left input onto left output
    localparam int P_RR = 1;   // right input onto right output
    localparam int P_LR = 2;   // left input onto right output
    localparam int P_RL = 3;   // right input onto left output

    typedef logic [ATT_W-1:0]  att_t;
    typedef logic [COEF_W-1:0] coef_t;

    // Coefficient for 0..5 dB, unity at 2**FRAC_W
    function automatic coef_t step_coef(input logic [2:0] idx);
        case (idx)
            3'd0:    return coef_t'(32768);
            3'd1:    return coef_t'(29205);
            3'd2:    return coef_t'(26029);
            3'd3:    return coef_t'(23198);
            3'd4:    return coef_t'(20675);
            default: return coef_t'(18427);
        endcase
    endfunction
endpackage

// File: rtl/xmix_regs.sv
// Attenuation setting storage for the four mixing paths.
// Assumes one write per cycle at most; direct paths reset to full level,
// cross paths reset to muted.
module xmix_regs
    import xmix_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  att_t                          wdata,
    output logic [N_PATH-1:0][ATT_W-1:0]  att_q
);
    localparam att_t DIRECT_RST = '0;
    localparam att_t CROSS_RST  = '1;

    for (genvar p = 0; p < N_PATH; p++) begin : g_reg
        localparam att_t RST_VAL = (p == P_LL || p == P_RR) ? DIRECT_RST : CROSS_RST;

        // Hold one path's setting; load it when selected by a write
        always_ff @(posedge clk) begin
            if (!rst_n)
                att_q[p] <= RST_VAL;
            else if (we && sel == SEL_W'(p))
                att_q[p] <= wdata;
        end
    end
endmodule

// File: rtl/xmix_gain_lut.sv
// Converts a dB-step attenuation setting into a linear coefficient.
// Assumes settings at or above MUTE_AT mean silence; below it the gain
// halves every STEPS settings, with a six-entry table for the remainder.
module xmix_gain_lut
    import xmix_pkg::*;
(
    input  att_t  att,
    output coef_t coef
);
    logic [2:0]       rem;
    logic [ATT_W-1:0] shift;

    // Split the setting into a table index and a halving count, then scale
    always_comb begin
        rem   = 3'(att % ATT_W'(STEPS));
        shift = att / ATT_W'(STEPS);
        if (att >= ATT_W'(MUTE_AT))
            coef = '0;
        else
            coef = step_coef(rem) >> shift;
    end
endmodule

// File: rtl/xmix_scale.sv
// One attenuator path: multiplies a signed sample by an unsigned
// coefficient, floors away the fractional bits and registers the term.
// Assumes the coefficient never exceeds unity, so the term fits DATA_W.
module xmix_scale
    import xmix_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] sample,
    input  coef_t                    coef,
    output logic signed [DATA_W-1:0] term
);
    localparam int FULL_W = DATA_W + COEF_W + 1;

    logic signed [FULL_W-1:0] full;

    // Exact product with the coefficient treated as non-negative
    always_comb begin
        full = FULL_W'(sample) * $signed({1'b0, coef});
    end

    // Register the floored term when a sample is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            term <= '0;
        else if (en)
            term <= DATA_W'(full >>> FRAC_W);
    end
endmodule

// File: rtl/xmix_combine.sv
// Adds two scaled terms for one output and clips to the signed range.
// Assumes both terms are already DATA_W wide; output holds between pairs.
module xmix_combine #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] y
);
    localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0]   sum;
    logic signed [DATA_W-1:0] clipped;

    // Widen by one bit, add, and clip when the top two bits disagree
    always_comb begin
        sum = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        if (sum[DATA_W] != sum[DATA_W-1])
            clipped = sum[DATA_W] ? NEG_MAX : POS_MAX;
        else
            clipped = sum[DATA_W-1:0];
    end

    // Register the clipped sum on a valid term pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= '0;
        else if (en)
            y <= clipped;
    end
endmodule

// File: rtl/stereo_xmix.sv
// Stereo volume and cross-mix butterfly, top level.
// Stage 1 samples the inputs with coefficients looked up from the current
// settings (the snapshot that keeps a pair consistent); stage 2 sums and
// clips. Assumes the input strobe marks one pair per high cycle.
module stereo_xmix
    import xmix_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [ATT_W-1:0]         cfg_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    logic [N_PATH-1:0][ATT_W-1:0]  att_q;
    coef_t                         coef   [N_PATH];
    logic signed [DATA_W-1:0]      term   [N_PATH];
    logic                          s1_valid;

    xmix_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_data),
        .att_q (att_q)
    );

    // Even paths take the left input, odd paths the right
    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        xmix_gain_lut u_lut (
            .att  (att_q[p]),
            .coef (coef[p])
        );

        xmix_scale #(.DATA_W(DATA_W)) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (in_valid),
            .sample ((p % 2 == 0) ? in_left : in_right),
            .coef   (coef[p]),
            .term   (term[p])
        );
    end

    xmix_combine #(.DATA_W(DATA_W)) u_left (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s1_valid),
        .a     (term[P_LL]),
        .b     (term[P_RL]),
        .y     (out_left)
    );

    xmix_combine #(.DATA_W(DATA_W)) u_right (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s1_valid),
        .a     (term[P_RR]),
        .b     (term[P_LR]),
        .y     (out_right)
    );

    // Carry the strobe alongside the two data stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end
endmodule

// File: rtl/xmix_chk.sv
// Property checker for stereo_xmix, attached by bind below.
// Assumes the inputs are held low during reset.
module xmix_chk
    import xmix_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          out_valid,
    input  logic signed [DATA_W-1:0]      out_left,
    input  logic signed [DATA_W-1:0]      out_right,
    input  logic [N_PATH-1:0][ATT_W-1:0]  att_q
);
    // R8: every accepted pair yields a strobe two cycles later
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R8: no strobe without a pair two cycles earlier
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R1: settings leave reset at full direct level and muted cross paths
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (att_q[P_LL] == 8'h00 && att_q[P_RR] == 8'h00 &&
                           att_q[P_LR] == 8'hFF && att_q[P_RL] == 8'hFF));

    // R4: both left contributions muted at acceptance gives a zero left output
    a_r4_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(att_q[P_LL] >= ATT_W'(MUTE_AT) &&
                            att_q[P_RL] >= ATT_W'(MUTE_AT), 2)) |-> out_left == '0);

    // R4: same for the right output
    a_r4_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(att_q[P_RR] >= ATT_W'(MUTE_AT) &&
                            att_q[P_LR] >= ATT_W'(MUTE_AT), 2)) |-> out_right == '0);
endmodule

bind stereo_xmix xmix_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .att_q     (att_q)
);

// File: tb/stereo_xmix_test.sv
`timescale 1ns/1ps
module stereo_xmix_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_sel = '0;
    logic [7:0]         cfg_data = '0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mirror [4];   // expected settings: ll, rr, lr, rl (R2 encoding)

    stereo_xmix uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right)
    );

    always #10 clk = ~clk;

    // Coefficient law of R3 and R4
    function automatic longint gain(input int n);
        int base [6] = '{32768, 29205, 26029, 23198, 20675, 18427};
        if (n >= 96) return 0;
        return longint'(base[n % 6] >> (n / 6));
    endfunction

    // Output model of R5 and R6
    function automatic int mix(input int own, input int own_att,
                               input int other, input int other_att);
        longint s;
        s = ((longint'(own) * gain(own_att)) >>> 15) +
            ((longint'(other) * gain(other_att)) >>> 15);
        if (s > 8388607)  s = 8388607;
        if (s < -8388608) s = -8388608;
        return int'(s);
    endfunction

    task automatic chk_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_att(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        mirror[sel] = val;
    endtask

    // Send one pair and check both outputs two cycles later
    task automatic send_check(input string req, input int l, input int r);
        int el, er;
        el = mix(l, mirror[0], r, mirror[3]);
        er = mix(r, mirror[1], l, mirror[2]);
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk_val({req, " valid"}, int'(out_valid), 1);
        chk_val({req, " left"}, int'(out_left), el);
        chk_val({req, " right"}, int'(out_right), er);
    endtask

    task automatic t_reset;   // R1, R8
        chk_val("R8 reset valid", int'(out_valid), 0);
        chk_val("R8 reset left", int'(out_left), 0);
        chk_val("R8 reset right", int'(out_right), 0);
        send_check("R1 pass", 24'sh123456, -344865);
        send_check("R1 pass neg", -8388608, 8388607);
    endtask

    task automatic t_law;   // R2, R3, R5
        write_att(0, 6);
        send_check("R3 six dB", 1000001, 0);
        write_att(0, 1); write_att(1, 13);
        send_check("R3 one/13 dB", -7654321, 5555555);
        write_att(0, 90);
        send_check("R3 90 dB", 8388607, -8388608);
        chk_val("R3 90 dB value", int'(out_left), 255);
        write_att(2, 6); write_att(1, 255);
        send_check("R2 cross sel2", 4000000, 123);
        chk_val("R2 cross value", int'(out_right), 2000000);
    endtask

    task automatic t_mute;   // R4
        write_att(0, 96); write_att(1, 255); write_att(2, 255); write_att(3, 200);
        send_check("R4 mute", 8388607, -8388608);
        chk_val("R4 left zero", int'(out_left), 0);
        chk_val("R4 right zero", int'(out_right), 0);
    endtask

    task automatic t_mix;   // R5, R9
        write_att(0, 0); write_att(1, 3); write_att(2, 12); write_att(3, 6);
        send_check("R5 mix", -3333333, 2222221);
        write_att(0, 255); write_att(1, 255); write_att(2, 0); write_att(3, 0);
        send_check("R9 swap", 1111111, -2222222);
        chk_val("R9 left is right", int'(out_left), -2222222);
        chk_val("R9 right is left", int'(out_right), 1111111);
    endtask

    task automatic t_sat;   // R6
        write_att(0, 0); write_att(1, 0); write_att(2, 0); write_att(3, 0);
        send_check("R6 pos clip", 8388607, 8388607);
        chk_val("R6 pos limit", int'(out_left), 8388607);
        send_check("R6 neg clip", -8388608, -8388608);
        chk_val("R6 neg limit", int'(out_right), -8388608);
        send_check("R6 partial", 6291456, 3145728);
        send_check("R6 no clip", 8388607, -8388608);
        chk_val("R6 in range", int'(out_left), -1);
    endtask

    // R7 snapshot and R8 back-to-back timing
    task automatic t_snapshot;
        int e0l, e0r, e1l, e1r;
        write_att(0, 0); write_att(1, 0); write_att(2, 255); write_att(3, 255);
        e0l = mix(500000, 0, 700000, 255);
        e0r = mix(700000, 0, 500000, 255);
        e1l = mix(600000, 12, 800000, 255);
        e1r = mix(800000, 0, 600000, 255);
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(500000); in_right = 24'(700000);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 8'd12;
        @(negedge clk);
        cfg_we = 1'b0; mirror[0] = 12;
        in_left = 24'(600000); in_right = 24'(800000);
        @(negedge clk);
        in_valid = 1'b0;
        chk_val("R7 old set left", int'(out_left), e0l);
        chk_val("R7 old set right", int'(out_right), e0r);
        chk_val("R8 first valid", int'(out_valid), 1);
        @(negedge clk);
        chk_val("R7 new set left", int'(out_left), e1l);
        chk_val("R7 new set right", int'(out_right), e1r);
        chk_val("R8 second valid", int'(out_valid), 1);
        @(negedge clk);
        chk_val("R8 valid drops", int'(out_valid), 0);
    endtask

    initial begin
        mirror = '{0, 0, 255, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_law();
        t_mute();
        t_mix();
        t_sat();
        t_snapshot();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule